// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a clocked host and an external asynchronous static RAM of 512K bytes. The host places one read or write request at a time through a request/ready handshake. The block then produces the strobe sequence the memory needs. That sequence covers the active-low chip select, output enable and write strobe, a registered address, and a split data bus: one output, one input and a drive-enable for the pad buffer.

Every phase length is a whole number of clock cycles. Each one is worked out at elaboration time as the ceiling of a nanosecond minimum divided by the clock period, and is never less than one cycle. A read holds select and output enable low until the later of the two access minimums has passed. The byte is captured on that edge and flagged valid for one cycle. A write holds select and write strobe low with output enable high, and drives the data for the whole window. Both strobes rise together, and the data stays on the bus for one more cycle. Before the block drives the bus after a read, it waits out the time the memory may keep driving after output enable rises.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and directly after it, `mem_cs_n`, `mem_oe_n` and `mem_wr_n` are 1, `mem_dq_drv` and `host_rvalid` are 0, and `host_ready` is 1.
- R2: A read holds `mem_cs_n` and `mem_oe_n` at 0 with `mem_wr_n` at 1. The byte is sampled no sooner than 70 ns after the later of the address change and the chip-select fall, and no sooner than 35 ns after the output-enable fall. `host_rdata` equals the byte stored at the requested address.
- R3: Each accepted read gives exactly one `host_rvalid` pulse, one cycle wide, with `host_rdata` valid in that cycle.
- R4: A write holds `mem_cs_n` and `mem_wr_n` at 0 while `mem_oe_n` stays 1. The memory stores `host_wdata` at `host_addr`.
- R5: In a write, `mem_wr_n` is low for at least 55 ns. `mem_cs_n` is low for at least 60 ns before the write ends. The written data is stable for at least 30 ns before the end, and the address is stable for at least 60 ns before the end and does not change after the write starts.
- R6: At the edge that ends a write, the data is still driven and the address is unchanged. The address stays constant for as long as `mem_cs_n` is low.
- R7: Two consecutive falls of `mem_cs_n` are at least 70 ns apart, including for back-to-back requests.
- R8: `host_ready` is 0 from the accepting edge until the cycle-time count has elapsed, and it is 0 whenever `mem_cs_n` is 0. A request is taken only on an edge where `host_req` and `host_ready` are both 1.
- R9: `mem_dq_drv` is 1 only while `mem_oe_n` is 1. It rises only after `mem_oe_n` has been high for at least 25 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_req | input | 1 | Request valid |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Byte address |
| host_wdata | input | 8 | Write byte |
| host_ready | output | 1 | Request accepted on an edge where this and host_req are 1 |
| host_rdata | output | 8 | Captured read byte |
| host_rvalid | output | 1 | One-cycle flag for host_rdata |
| mem_addr | output | 19 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | 8 | Data toward memory |
| mem_dq_in | input | 8 | Data from memory |
| mem_dq_drv | output | 1 | Enables the controller's data drivers |

## Verification
The bench uses a timing-aware memory model. The model returns a poison byte whenever it is sampled before either access minimum has passed, so reads taken too early show up as miscompares. Its write-end hook measures the strobe widths, the data and address setup, and the data hold.

Writes go to the lowest and highest addresses and to scattered ones, and each is read back. This separates correct address and data routing from swapped or truncated bits. Back-to-back writes and back-to-back reads exercise the start-to-start spacing. A write right after a read exercises the bus turnaround, which the model checks against its 25 ns release time. A write that overwrites a location and is then read back separates real storage from stale capture.

// File: rtl/asram_pkg.sv
`timescale 1ns/10ps
// Package: shared helpers and types for the asynchronous SRAM controller.
// Assumes integer nanosecond minimums and an integer clock period in ns.
package asram_pkg;

    // Cycles needed to cover a nanosecond minimum; at least one if nonzero.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        if (ns <= 0) return 0;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT_BUS,
        ST_WRITE,
        ST_WR_HOLD
    } seq_state_t;

endpackage

// File: rtl/asram_dcnt.sv
`timescale 1ns/10ps
// Module: loadable down-counter that stops at zero.
// Used for the start-to-start cycle timer and the bus turnaround timer.
// Assumes load has priority over counting.
module asram_dcnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Load a new count or step toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (load)          cnt <= load_val;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/10ps
// Module: strobe sequencer. Drives the chip select, output enable, write
// strobe and data-drive enable from an accepted request.
// Assumes acc is only asserted while idle is 1, and that bus_free reports
// that the turnaround after the last read has elapsed.
module asram_seq #(
    parameter int CW        = 5,
    parameter int N_RA      = 14,
    parameter int N_WP      = 12,
    parameter int N_HZ      = 5,
    parameter int CLK_NS    = 5,
    parameter int T_PWE_NS  = 55
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc,
    input  logic acc_we,
    input  logic bus_free,
    output logic cs_n,
    output logic oe_n,
    output logic wr_n,
    output logic drv,
    output logic cap,
    output logic arm_cyc,
    output logic arm_turn,
    output logic idle
);
    import asram_pkg::*;

    localparam logic [CW-1:0] RA_LD = CW'(N_RA - 1);
    localparam logic [CW-1:0] WP_LD = CW'(N_WP - 1);
    localparam logic [CW-1:0] HZ_SAT = CW'(N_HZ);

    seq_state_t   state;
    logic [CW-1:0] ph;
    logic          start_rd, start_wr;

    // Decode phase starts and the capture strobe.
    always_comb begin
        idle     = (state == ST_IDLE);
        start_rd = idle && acc && !acc_we;
        start_wr = (idle && acc && acc_we && bus_free) ||
                   ((state == ST_WAIT_BUS) && bus_free);
        cap      = (state == ST_READ) && (ph == '0);
        arm_turn = cap;
        arm_cyc  = start_rd || start_wr;
    end

    // Sequence the strobes through read, wait, write and hold phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ph    <= '0;
            cs_n  <= 1'b1;
            oe_n  <= 1'b1;
            wr_n  <= 1'b1;
            drv   <= 1'b0;
        end else if (start_rd) begin
            state <= ST_READ;
            ph    <= RA_LD;
            cs_n  <= 1'b0;
            oe_n  <= 1'b0;
        end else if (start_wr) begin
            state <= ST_WRITE;
            ph    <= WP_LD;
            cs_n  <= 1'b0;
            wr_n  <= 1'b0;
            drv   <= 1'b1;
        end else begin
            unique case (state)
                ST_IDLE:     if (acc) state <= ST_WAIT_BUS;
                ST_WAIT_BUS: state <= ST_WAIT_BUS;
                ST_READ: begin
                    if (ph == '0) begin
                        cs_n  <= 1'b1;
                        oe_n  <= 1'b1;
                        state <= ST_IDLE;
                    end else ph <= ph - 1'b1;
                end
                ST_WRITE: begin
                    if (ph == '0) begin
                        cs_n  <= 1'b1;
                        wr_n  <= 1'b1;
                        state <= ST_WR_HOLD;
                    end else ph <= ph - 1'b1;
                end
                ST_WR_HOLD: begin
                    drv   <= 1'b0;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Checker counters: cycles output enable has been high, cycles strobe low.
    logic [CW-1:0] oe_hi_cnt, wr_lo_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_hi_cnt <= HZ_SAT;
            wr_lo_cnt <= '0;
        end else begin
            if (!oe_n)                 oe_hi_cnt <= '0;
            else if (oe_hi_cnt < HZ_SAT) oe_hi_cnt <= oe_hi_cnt + 1'b1;
            if (wr_n)                  wr_lo_cnt <= '0;
            else if (wr_lo_cnt != '1)  wr_lo_cnt <= wr_lo_cnt + 1'b1;
        end
    end

    assert_wr_excl_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> oe_n);
    assert_drv_oe_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drv |-> oe_n);
    assert_turnaround_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv) |-> (oe_hi_cnt >= HZ_SAT));
    assert_wr_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (int'(wr_lo_cnt) * CLK_NS >= T_PWE_NS));
endmodule

// File: rtl/asram_dpath.sv
`timescale 1ns/10ps
// Module: request and read-data registers. Latches address and write byte
// on acceptance, captures the memory byte on cap and flags it for a cycle.
// Assumes acc never arrives while chip select is low.
module asram_dpath #(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    input  logic          cap,
    input  logic [DW-1:0] mem_rd,
    input  logic          cs_n,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    // Hold the request fields for the whole memory cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (acc) begin
            addr_q  <= acc_addr;
            wdata_q <= acc_wdata;
        end
    end

    // Capture read data and raise the one-cycle valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= cap;
            if (cap) rdata <= mem_rd;
        end
    end

    assert_rvalid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);
    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> $stable(addr_q));
endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/10ps
// Module: top of the asynchronous SRAM controller. Converts host
// request/ready transfers into memory strobe cycles with phase lengths
// derived from nanosecond minimums and CLK_NS.
// Assumes one outstanding request and an external tri-state pad using
// mem_dq_drv.
module asram_ctrl #(
    parameter int AW         = 19,
    parameter int DW         = 8,
    parameter int CLK_NS     = 5,
    parameter int T_RC_NS    = 70,
    parameter int T_AA_NS    = 70,
    parameter int T_DOE_NS   = 35,
    parameter int T_WC_NS    = 70,
    parameter int T_PWE_NS   = 55,
    parameter int T_SCE_NS   = 60,
    parameter int T_SD_NS    = 30,
    parameter int T_AW_NS    = 60,
    parameter int T_HZOE_NS  = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_req,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic          host_ready,
    output logic [DW-1:0] host_rdata,
    output logic          host_rvalid,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_oe_n,
    output logic          mem_wr_n,
    output logic [DW-1:0] mem_dq_out,
    input  logic [DW-1:0] mem_dq_in,
    output logic          mem_dq_drv
);
    import asram_pkg::*;

    localparam int N_RA  = imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_DOE_NS, CLK_NS));
    localparam int N_WP  = imax(imax(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_SCE_NS, CLK_NS)),
                                imax(ns_to_cyc(T_SD_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)));
    localparam int N_CYC = imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_WC_NS, CLK_NS));
    localparam int N_HZ  = ns_to_cyc(T_HZOE_NS, CLK_NS);
    localparam int N_MAX = imax(imax(N_RA, N_WP), imax(N_CYC, N_HZ));
    localparam int CW    = $clog2(N_MAX + 1) + 1;

    logic acc, cap, arm_cyc, arm_turn, idle, cyc_zero, bus_free;

    // Accept only when idle and the start-to-start count has run out.
    always_comb begin
        host_ready = idle && cyc_zero;
        acc        = host_req && host_ready;
    end

    asram_dcnt #(.W(CW)) u_cyc (
        .clk(clk), .rst_n(rst_n), .load(arm_cyc),
        .load_val(CW'(N_CYC)), .zero(cyc_zero)
    );

    asram_dcnt #(.W(CW)) u_turn (
        .clk(clk), .rst_n(rst_n), .load(arm_turn),
        .load_val(CW'(N_HZ)), .zero(bus_free)
    );

    asram_seq #(
        .CW(CW), .N_RA(N_RA), .N_WP(N_WP), .N_HZ(N_HZ),
        .CLK_NS(CLK_NS), .T_PWE_NS(T_PWE_NS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .acc(acc), .acc_we(host_we),
        .bus_free(bus_free), .cs_n(mem_cs_n), .oe_n(mem_oe_n),
        .wr_n(mem_wr_n), .drv(mem_dq_drv), .cap(cap),
        .arm_cyc(arm_cyc), .arm_turn(arm_turn), .idle(idle)
    );

    asram_dpath #(.AW(AW), .DW(DW)) u_dp (
        .clk(clk), .rst_n(rst_n), .acc(acc), .acc_addr(host_addr),
        .acc_wdata(host_wdata), .cap(cap), .mem_rd(mem_dq_in),
        .cs_n(mem_cs_n), .addr_q(mem_addr), .wdata_q(mem_dq_out),
        .rdata(host_rdata), .rvalid(host_rvalid)
    );

    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !host_ready);
endmodule

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/10ps
// Bench: scoreboard with a timing-aware memory model.
module sim_asram_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [18:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ready, host_rvalid;
    logic [7:0]  host_rdata;
    logic [18:0] mem_addr;
    logic        mem_cs_n, mem_oe_n, mem_wr_n, mem_dq_drv;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    always #2.5 clk = ~clk;

    asram_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_wr_n(mem_wr_n),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_drv(mem_dq_drv)
    );

    int n_chk = 0, n_fail = 0;
    bit armed = 1'b0, done = 1'b0;
    logic [7:0]  store  [int];
    logic [7:0]  shadow [int];
    logic [7:0]  exp_q [$];
    logic [26:0] wr_q  [$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Memory model timestamps.
    realtime t_addr = 0, t_cs_fall = 0, t_oe_fall = 0, t_oe_rise = -1000;
    realtime t_wr_fall = 0, t_dat = 0, t_start = -1000;
    bit      have_start = 1'b0;
    wire     wr_act = !mem_cs_n && !mem_wr_n;

    always @(mem_addr) t_addr = $realtime;
    always @(mem_dq_out or mem_dq_drv) t_dat = $realtime;
    always @(negedge mem_oe_n) t_oe_fall = $realtime;
    always @(posedge mem_oe_n) if (armed) t_oe_rise = $realtime;
    always @(negedge mem_wr_n) t_wr_fall = $realtime;

    // Chip-select fall: start-to-start spacing.
    always @(negedge mem_cs_n) begin
        t_cs_fall = $realtime;
        if (armed) begin
            if (have_start)
                chk(($realtime - t_start) >= 70.0, "R7 start-to-start ns",
                    32'(int'($realtime - t_start)), 32'd70);
            t_start = $realtime;
            have_start = 1'b1;
        end
    end

    // Write end: timing, hold and storage.
    always @(negedge wr_act) begin
        if (armed) begin
            realtime t;
            logic [26:0] e;
            t = $realtime;
            chk((t - t_wr_fall) >= 55.0, "R5 strobe width ns", 32'(int'(t - t_wr_fall)), 32'd55);
            chk((t - t_cs_fall) >= 60.0, "R5 select to end ns", 32'(int'(t - t_cs_fall)), 32'd60);
            chk((t - t_dat) >= 30.0, "R5 data setup ns", 32'(int'(t - t_dat)), 32'd30);
            chk((t - t_addr) >= 60.0 && t_addr <= t_wr_fall, "R5 address setup ns",
                32'(int'(t - t_addr)), 32'd60);
            chk(mem_dq_drv == 1'b1, "R6 data driven at write end", 32'(mem_dq_drv), 32'd1);
            chk(mem_oe_n == 1'b1, "R4 output enable high in write", 32'(mem_oe_n), 32'd1);
            if (wr_q.size() == 0) chk(1'b0, "R4 unexpected write", 32'(mem_addr), 32'd0);
            else begin
                e = wr_q.pop_front();
                chk({mem_addr, mem_dq_out} == e, "R4 written addr/data",
                    {5'd0, mem_addr, mem_dq_out}, {5'd0, e});
            end
            store[int'(mem_addr)] = mem_dq_out;
        end
    end

    // Read data driver: poison until access minimums have passed.
    initial begin
        #0.25;
        forever begin
            realtime ta;
            #0.5;
            ta = (t_addr > t_cs_fall) ? t_addr : t_cs_fall;
            if (armed && !mem_cs_n && !mem_oe_n && mem_wr_n &&
                ($realtime - ta) >= 69.0 && ($realtime - t_oe_fall) >= 34.0)
                mem_dq_in = store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : 8'h00;
            else
                mem_dq_in = 8'hEE;
        end
    end

    // Monitor: scoreboard pop, pulse width, bus contention.
    bit rv_prev = 1'b0, drv_prev = 1'b0;
    always @(negedge clk) begin
        if (armed) begin
            if (host_rvalid) begin
                chk(!rv_prev, "R3 valid one cycle", 32'(rv_prev), 32'd0);
                if (exp_q.size() == 0) chk(1'b0, "R3 extra valid", 32'(host_rdata), 32'd0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(host_rdata == e, "R2 read data", 32'(host_rdata), 32'(e));
                end
            end
            if (!mem_cs_n) chk(!host_ready, "R8 ready low while selected", 32'(host_ready), 32'd0);
            if (mem_dq_drv && !drv_prev)
                chk(mem_oe_n && ($realtime - t_oe_rise) >= 25.0, "R9 drive after release ns",
                    32'(int'($realtime - t_oe_rise)), 32'd25);
            if (!mem_oe_n && !mem_cs_n)
                chk(mem_wr_n && !mem_dq_drv, "R2 read strobes", {mem_wr_n, mem_dq_drv}, 32'd2);
        end
        rv_prev  = host_rvalid;
        drv_prev = mem_dq_drv;
    end

    // Driver: wait for ready, present a request for one edge.
    task automatic issue(input bit we, input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
        chk(!host_ready, "R8 ready low after accept", 32'(host_ready), 32'd0);
    endtask

    task automatic do_write(input logic [18:0] a, input logic [7:0] d);
        shadow[int'(a)] = d;
        wr_q.push_back({a, d});
        issue(1'b1, a, d);
    endtask

    task automatic do_read(input logic [18:0] a);
        exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
        issue(1'b0, a, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_oe_n && mem_wr_n, "R1 strobes idle in reset",
            {mem_cs_n, mem_oe_n, mem_wr_n}, 32'd7);
        chk(!mem_dq_drv && !host_rvalid, "R1 drive/valid low", {mem_dq_drv, host_rvalid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(host_ready, "R1 ready after reset", 32'(host_ready), 32'd1);
        armed = 1'b1;
        // Back-to-back writes across the address range.
        do_write(19'h00000, 8'h11);
        do_write(19'h7FFFF, 8'hA5);
        do_write(19'h12345, 8'h3C);
        do_write(19'h55555, 8'hFF);
        do_write(19'h2AAAA, 8'h00);
        // Back-to-back reads.
        do_read(19'h00000);
        do_read(19'h7FFFF);
        do_read(19'h12345);
        do_read(19'h55555);
        do_read(19'h2AAAA);
        // Write straight after read: bus turnaround.
        do_write(19'h12345, 8'h96);
        do_read(19'h12345);
        do_write(19'h40001, 8'h5A);
        do_write(19'h40001, 8'h69);
        do_read(19'h40001);
        do_read(19'h7FFFF);
        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0, "R3 one valid per read", 32'(exp_q.size()), 32'd0);
        chk(wr_q.size() == 0, "R4 every write reached memory", 32'(wr_q.size()), 32'd0);
        chk(host_ready && mem_cs_n, "R8 ready after final cycle", {host_ready, mem_cs_n}, 32'd3);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=0 exp=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule